// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a transmit command FIFO and a byte-level I2C engine. Each 11-bit command word names one data byte, says whether that byte is read or written, and may ask for a repeated start before the byte or a stop after it. The sequencer turns the words into engine operations: start, the address bytes (7-bit or 10-bit), data write, data read, repeated start and stop. Received bytes go into a receive FIFO.

Failures end the transfer as an abort. The cause is recorded as a bit in a sticky reason vector, and both FIFOs are flushed. Two threshold comparators raise the transmit-low and receive-high events that software uses to refill and drain the FIFOs. The FIFO arrays, the bit-level SCL/SDA shifter and the register bus are outside the block and reach it through simple ports.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word carries write data in bits 7:0, a read flag in bit 8, stop-after in bit 9 and restart-before in bit 10. The engine operation codes are 0 start, 1 restart, 2 write, 3 read and 4 stop. `eng_byte` is zero for every operation except write, and a write carries the command's data byte.
- R2: In 7-bit mode, a transfer starts with a start operation and then writes the address byte `{addr[6:0], read}`.
- R3: With `tar_ten` set, the address phase writes `{5'b11110, addr[9:8], 0}` and then `addr[7:0]`. For a read, it then issues a restart and writes `{5'b11110, addr[9:8], 1}`.
- R4: A command with the restart flag set, or one whose direction differs from the previous command, issues a restart and resends the address before its byte.
- R5: When a byte without stop completes and no command is waiting, `hold_scl` and `busy` stay high and no engine request is made until the next command arrives.
- R6: Each completed read pushes the engine's received byte to the receive FIFO in the same cycle.
- R7: An address NACK sets abort bit 0 in 7-bit mode. In 10-bit mode it sets bit 1 for the first (or read-phase) high byte and bit 2 for the low byte.
- R8: A NACK on written data sets bit 3. A NACK on the general-call address (7-bit address 0) sets bit 4. A read command to the general-call address sets bit 5 and issues no operation.
- R9: Lost arbitration sets bit 12 and the block returns to idle without a stop. A command taken while `enable` is low sets bit 11, and a 10-bit read while `restart_en` is low sets bit 10; neither issues an operation.
- R10: Every abort pulses `flush` for one cycle. Reason bits accumulate until `abort_clr`. After a NACK, a stop operation is issued.
- R11: `busy` is low in reset and idle, and high from command acceptance until the final stop completes.
- R12: `tx_empty_evt` is high exactly when `tx_level <= tx_thr`, and `rx_full_evt` is high exactly when `rx_level > rx_thr`.
- R13: A target address write while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| restart_en | input | 1 | Repeated starts permitted |
| tar_we | input | 1 | Target address write strobe |
| tar_ten | input | 1 | 10-bit addressing select for the write |
| tar_addr | input | 10 | Target address for the write |
| cmd_valid | input | 1 | Command FIFO not empty |
| cmd_data | input | 11 | Command FIFO head word |
| cmd_pop | output | 1 | Remove head command |
| eng_req | output | 1 | Engine operation request, held until done |
| eng_op | output | 3 | Engine operation code |
| eng_byte | output | 8 | Byte to send for write operations |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_nack | input | 1 | Written byte was not acknowledged |
| eng_arb_lost | input | 1 | Arbitration lost during the operation |
| eng_rdata | input | 8 | Byte received by a read operation |
| rx_push | output | 1 | Push into receive FIFO |
| rx_data | output | 8 | Byte pushed |
| flush | output | 1 | Flush both FIFOs |
| abort_src | output | 13 | Sticky abort reason vector |
| abort_clr | input | 1 | Clear abort reasons |
| busy | output | 1 | Transfer in progress |
| hold_scl | output | 1 | Waiting for a command with the clock held low |
| tx_level | input | LW | Command FIFO fill level |
| tx_thr | input | LW | Transmit threshold |
| rx_level | input | LW | Receive FIFO fill level |
| rx_thr | input | LW | Receive threshold |
| tx_empty_evt | output | 1 | Command FIFO at or below threshold |
| rx_full_evt | output | 1 | Receive FIFO above threshold |

## Verification
A wrong sequencer state shows up at the engine port when the next operation completes. The operation is then the wrong code, carries the wrong address byte, is an extra one, or is missing. A corrupted direction or address register appears in the very next address byte, and a missed abort shows as a missing `flush` pulse or wrong reason bits once the transfer settles. The bench checks every engine operation against an expected list built from the requirements, and checks the receive push on each read completion and the threshold events on every clock.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          restart_en,
  input  logic          tar_we,
  input  logic          tar_ten,
  input  logic [9:0]    tar_addr,
  input  logic          cmd_valid,
  input  logic [10:0]   cmd_data,
  output logic          cmd_pop,
  output logic          eng_req,
  output logic [2:0]    eng_op,
  output logic [7:0]    eng_byte,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic          eng_arb_lost,
  input  logic [7:0]    eng_rdata,
  output logic          rx_push,
  output logic [7:0]    rx_data,
  output logic          flush,
  output logic [12:0]   abort_src,
  input  logic          abort_clr,
  output logic          busy,
  output logic          hold_scl,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_thr,
  output logic          tx_empty_evt,
  output logic          rx_full_evt
);
  localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_WRITE = 3'd2,
                         OP_READ = 3'd3, OP_STOP = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_A1, S_A2, S_RS10, S_A3, S_DATA, S_HOLD, S_STOP
  } st_t;

  st_t         st;
  logic [7:0]  cur_byte;
  logic        cur_stop, rd, rs, ten;
  logic [9:0]  tar;
  logic [12:0] pre_bits, done_bits, new_bits;

  wire       accept = (st == S_IDLE || st == S_HOLD) && cmd_valid;
  wire       fin    = eng_req && eng_done;
  wire       gcall  = !ten && (tar[6:0] == 7'd0);
  wire [6:0] hi     = {5'b11110, tar[9:8]};

  assign cmd_pop      = accept;
  assign eng_req      = !(st == S_IDLE || st == S_HOLD);
  assign busy         = (st != S_IDLE);
  assign hold_scl     = (st == S_HOLD);
  assign rx_push      = fin && st == S_DATA && rd && !eng_arb_lost;
  assign rx_data      = eng_rdata;
  assign tx_empty_evt = (tx_level <= tx_thr);
  assign rx_full_evt  = (rx_level > rx_thr);

  always_comb begin
    pre_bits = '0;
    if (!enable) pre_bits[11] = 1'b1;
    else if (gcall && cmd_data[8]) pre_bits[5] = 1'b1;
    else if (ten && cmd_data[8] && !restart_en) pre_bits[10] = 1'b1;
  end

  always_comb begin
    done_bits = '0;
    if (eng_arb_lost) done_bits[12] = 1'b1;
    else if (eng_nack) begin
      case (st)
        S_A1: begin
          if (ten) done_bits[1] = 1'b1;
          else if (gcall) done_bits[4] = 1'b1;
          else done_bits[0] = 1'b1;
        end
        S_A2:   done_bits[2] = 1'b1;
        S_A3:   done_bits[1] = 1'b1;
        S_DATA: done_bits[3] = !rd;
        default: ;
      endcase
    end
  end

  assign new_bits = accept ? pre_bits : (fin ? done_bits : 13'd0);
  assign flush    = |new_bits;

  always_comb begin
    eng_op   = OP_WRITE;
    eng_byte = 8'h00;
    case (st)
      S_START: eng_op = rs ? OP_RESTART : OP_START;
      S_A1:    eng_byte = ten ? {hi, 1'b0} : {tar[6:0], rd};
      S_A2:    eng_byte = tar[7:0];
      S_RS10:  eng_op = OP_RESTART;
      S_A3:    eng_byte = {hi, 1'b1};
      S_DATA: begin
        eng_op   = rd ? OP_READ : OP_WRITE;
        eng_byte = rd ? 8'h00 : cur_byte;
      end
      S_STOP:  eng_op = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_byte  <= '0;
      cur_stop  <= 1'b0;
      rd        <= 1'b0;
      rs        <= 1'b0;
      ten       <= 1'b0;
      tar       <= '0;
      abort_src <= '0;
    end else begin
      abort_src <= (abort_clr ? 13'd0 : abort_src) | new_bits;
      if (tar_we && st == S_IDLE) begin
        ten <= tar_ten;
        tar <= tar_addr;
      end
      if (accept) begin
        if (|pre_bits) st <= (st == S_HOLD) ? S_STOP : S_IDLE;
        else begin
          cur_byte <= cmd_data[7:0];
          cur_stop <= cmd_data[9];
          rd       <= cmd_data[8];
          if (st == S_IDLE) begin
            st <= S_START;
            rs <= 1'b0;
          end else if (cmd_data[10] || cmd_data[8] != rd) begin
            st <= S_START;
            rs <= 1'b1;
          end else st <= S_DATA;
        end
      end else if (fin) begin
        if (eng_arb_lost || st == S_STOP) st <= S_IDLE;
        else if (|done_bits) st <= S_STOP;
        else begin
          case (st)
            S_START: st <= S_A1;
            S_A1:    st <= ten ? S_A2 : S_DATA;
            S_A2:    st <= rd ? S_RS10 : S_DATA;
            S_RS10:  st <= S_A3;
            S_A3:    st <= S_DATA;
            S_DATA:  st <= cur_stop ? S_STOP : S_HOLD;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid); // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> (busy && !eng_req)); // R5
  AST_PUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (eng_done && eng_op == OP_READ)); // R6
  AST_FLUSH_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !abort_clr) |=> (abort_src != 13'd0)); // R10
  AST_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!eng_req || eng_op == OP_STOP)); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy); // R11
  AST_TAR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tar) && $stable(ten))); // R13
endmodule

// File: tb/sim_i2c_cmd_seq.sv
module sim_i2c_cmd_seq;
  localparam int LW = 5;
  localparam logic [2:0] OS = 3'd0, ORS = 3'd1, OW = 3'd2, ORD = 3'd3, OP = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, restart_en = 1'b1, tar_we = 1'b0, tar_ten = 1'b0;
  logic [9:0] tar_addr = '0;
  logic cmd_valid = 1'b0;
  logic [10:0] cmd_data = '0;
  logic cmd_pop, eng_req, rx_push, flush, busy, hold_scl, tx_empty_evt, rx_full_evt;
  logic [2:0] eng_op;
  logic [7:0] eng_byte, rx_data;
  logic eng_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0, abort_clr = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic [12:0] abort_src;
  logic [LW-1:0] tx_level = '0, tx_thr = 5'd8, rx_level = '0, rx_thr = 5'd5;

  always #10 clk = ~clk;

  i2c_cmd_seq u0 (.*);

  logic [10:0] cmdq[$];
  logic [10:0] expq[$];
  int checks = 0, fails = 0, flushes = 0, op_idx = 0, nack_at = -1, arb_at = -1, cnt = 0, cyc = 0;
  bit pend_pop = 0, pend_flush = 0, done_flag = 0;
  string tag = "R11";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (pend_flush) cmdq.delete();
    else if (pend_pop && cmdq.size() > 0) void'(cmdq.pop_front());
    pend_pop = 0; pend_flush = 0;
    cmd_valid = (cmdq.size() > 0);
    cmd_data = cmd_valid ? cmdq[0] : 11'd0;
    cyc++;
    tx_level = LW'(cyc % 17);
    rx_level = LW'((cyc * 3) % 17);
    if (eng_done) begin
      eng_done = 0; eng_nack = 0; eng_arb_lost = 0; cnt = 0;
    end else if (eng_req) begin
      cnt++;
      if (cnt >= 2) begin
        if (expq.size() == 0)
          chk(0, tag, "unexpected engine op", {eng_op, eng_byte}, 0);
        else begin
          chk({eng_op, eng_byte} == expq[0], tag, "engine op/byte", {eng_op, eng_byte}, expq[0]);
          void'(expq.pop_front());
        end
        eng_done = 1;
        eng_nack = (op_idx == nack_at);
        eng_arb_lost = (op_idx == arb_at);
        eng_rdata = 8'h3C ^ 8'(op_idx);
        op_idx++;
      end
    end else cnt = 0;
    #2;
    pend_pop = cmd_pop;
    pend_flush = flush;
    if (flush) flushes++;
    if (eng_done && eng_op == ORD)
      chk(rx_push && rx_data == eng_rdata, "R6", "rx push data", {rx_push, rx_data}, {1'b1, eng_rdata});
    else if (rst_n)
      chk(!rx_push, "R6", "spurious rx push", rx_push, 0);
    if (rst_n) begin
      chk(tx_empty_evt == (tx_level <= tx_thr), "R12", "tx_empty_evt", tx_empty_evt, tx_level <= tx_thr);
      chk(rx_full_evt == (rx_level > rx_thr), "R12", "rx_full_evt", rx_full_evt, rx_level > rx_thr);
    end
  end

  function automatic logic [10:0] e(logic [2:0] op, logic [7:0] b);
    return {op, b};
  endfunction

  task automatic set_tar(bit t, logic [9:0] a);
    @(negedge clk); #5;
    tar_we = 1; tar_ten = t; tar_addr = a;
    @(negedge clk); #5;
    tar_we = 0;
  endtask

  task automatic begin_test(string t, int na, int ar);
    tag = t; op_idx = 0; nack_at = na; arb_at = ar;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #5;
      if (!busy && cmdq.size() == 0 && !eng_done) break;
    end
    repeat (3) @(negedge clk);
    #5;
    chk(expq.size() == 0, tag, "expected ops not issued", expq.size(), 0);
    chk(!busy, "R11", "busy after transfer", busy, 0);
  endtask

  task automatic clear_abort();
    @(negedge clk); #5; abort_clr = 1;
    @(negedge clk); #5; abort_clr = 0;
    chk(abort_src == 0, "R10", "abort_src after clear", abort_src, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "WATCHDOG", "run hung", 0, 1);
    summary();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    #5;
    chk(!busy && !eng_req && !hold_scl, "R11", "reset idle", {busy, eng_req, hold_scl}, 0);
    chk(abort_src == 0 && !flush, "R10", "reset abort state", abort_src, 0);
    rst_n = 1;
    set_tar(0, 10'h050);

    // R1 R2: 7-bit write, stop on last byte
    begin_test("R2", -1, -1);
    expq = '{e(OS,0), e(OW,8'hA0), e(OW,8'h11), e(OW,8'h22), e(OP,0)};
    cmdq.push_back(11'h011); cmdq.push_back(11'h222);
    wait_idle();

    // R1 R6: 7-bit read of two bytes
    begin_test("R1", -1, -1);
    expq = '{e(OS,0), e(OW,8'hA1), e(ORD,0), e(ORD,0), e(OP,0)};
    cmdq.push_back(11'h100); cmdq.push_back(11'h300);
    wait_idle();

    // R4: restart flag
    begin_test("R4", -1, -1);
    expq = '{e(OS,0), e(OW,8'hA0), e(OW,8'h33), e(ORS,0), e(OW,8'hA1), e(ORD,0), e(OP,0)};
    cmdq.push_back(11'h033); cmdq.push_back(11'h700);
    wait_idle();

    // R4: direction change without flag still restarts
    begin_test("R4", -1, -1);
    expq = '{e(OS,0), e(OW,8'hA0), e(OW,8'h44), e(ORS,0), e(OW,8'hA1), e(ORD,0), e(OP,0)};
    cmdq.push_back(11'h044); cmdq.push_back(11'h300);
    wait_idle();

    // R3: 10-bit write
    set_tar(1, 10'h2A5);
    begin_test("R3", -1, -1);
    expq = '{e(OS,0), e(OW,8'hF4), e(OW,8'hA5), e(OW,8'h55), e(OP,0)};
    cmdq.push_back(11'h255);
    wait_idle();

    // R3: 10-bit read
    begin_test("R3", -1, -1);
    expq = '{e(OS,0), e(OW,8'hF4), e(OW,8'hA5), e(ORS,0), e(OW,8'hF5), e(ORD,0), e(OP,0)};
    cmdq.push_back(11'h300);
    wait_idle();

    // R5 R13: hold with empty FIFO, address write ignored while busy
    set_tar(0, 10'h050);
    begin_test("R5", -1, -1);
    expq = '{e(OS,0), e(OW,8'hA0), e(OW,8'h66), e(ORS,0), e(OW,8'hA0), e(OW,8'h77), e(OP,0)};
    cmdq.push_back(11'h066);
    repeat (30) @(negedge clk);
    #5;
    chk(hold_scl && busy && !eng_req, "R5", "hold state", {hold_scl, busy, eng_req}, 3'b110);
    chk(busy, "R11", "busy while holding", busy, 1);
    set_tar(0, 10'h07F);
    tag = "R13";
    cmdq.push_back(11'h677);
    wait_idle();

    // R7 R10: 7-bit address NACK, queued commands flushed
    set_tar(0, 10'h050);
    begin_test("R7", 1, -1);
    f0 = flushes;
    expq = '{e(OS,0), e(OW,8'hA0), e(OP,0)};
    cmdq.push_back(11'h011); cmdq.push_back(11'h222);
    wait_idle();
    chk(abort_src == 13'h001, "R7", "7-bit addr nack reason", abort_src, 13'h001);
    chk(flushes - f0 == 1, "R10", "one flush pulse", flushes - f0, 1);

    // R8 R10: data NACK, reasons accumulate
    begin_test("R8", 2, -1);
    expq = '{e(OS,0), e(OW,8'hA0), e(OW,8'h11), e(OP,0)};
    cmdq.push_back(11'h011); cmdq.push_back(11'h222);
    wait_idle();
    chk(abort_src == 13'h009, "R10", "sticky reasons", abort_src, 13'h009);
    clear_abort();

    // R7: 10-bit first and second byte NACK
    set_tar(1, 10'h2A5);
    begin_test("R7", 1, -1);
    expq = '{e(OS,0), e(OW,8'hF4), e(OP,0)};
    cmdq.push_back(11'h255);
    wait_idle();
    chk(abort_src == 13'h002, "R7", "10-bit first byte nack", abort_src, 13'h002);
    clear_abort();
    begin_test("R7", 2, -1);
    expq = '{e(OS,0), e(OW,8'hF4), e(OW,8'hA5), e(OP,0)};
    cmdq.push_back(11'h255);
    wait_idle();
    chk(abort_src == 13'h004, "R7", "10-bit second byte nack", abort_src, 13'h004);
    clear_abort();

    // R8: general call NACK and general call read
    set_tar(0, 10'h000);
    begin_test("R8", 1, -1);
    expq = '{e(OS,0), e(OW,8'h00), e(OP,0)};
    cmdq.push_back(11'h211);
    wait_idle();
    chk(abort_src == 13'h010, "R8", "general call nack", abort_src, 13'h010);
    clear_abort();
    begin_test("R8", -1, -1);
    f0 = flushes;
    cmdq.push_back(11'h300);
    wait_idle();
    chk(abort_src == 13'h020, "R8", "general call read", abort_src, 13'h020);
    chk(flushes - f0 == 1, "R10", "flush on gcall read", flushes - f0, 1);
    clear_abort();

    // R9: lost arbitration, no stop
    set_tar(0, 10'h050);
    begin_test("R9", -1, 1);
    expq = '{e(OS,0), e(OW,8'hA0)};
    cmdq.push_back(11'h211);
    wait_idle();
    chk(abort_src == 13'h1000, "R9", "arbitration lost", abort_src, 13'h1000);
    clear_abort();

    // R9: command while disabled
    enable = 0;
    begin_test("R9", -1, -1);
    cmdq.push_back(11'h211);
    wait_idle();
    chk(abort_src == 13'h800, "R9", "use while disabled", abort_src, 13'h800);
    enable = 1;
    clear_abort();

    // R9: 10-bit read with restarts disabled
    restart_en = 0;
    set_tar(1, 10'h2A5);
    begin_test("R9", -1, -1);
    cmdq.push_back(11'h300);
    wait_idle();
    chk(abort_src == 13'h400, "R9", "10-bit read without restart", abort_src, 13'h400);
    restart_en = 1;
    clear_abort();

    summary();
  end
endmodule